// File: doc/BRIEF.md
# Registered Command Buffer with Reset Gating

This block is a single pipeline stage for DRAM address and control lines. It sits between a host-side command port and a group of memory devices. Each rising clock edge it captures the address, the chip selects, the three command strobes (RAS, CAS, WE) and the clock-enable line. It drives them to the devices one cycle later, so every command reaches the memory exactly one clock after it is presented.

An active-low reset acts without the clock. While it is low, every output is forced low, including the clock-enable line, and the memory devices see a steady low CKE. The system can then stop driving the command inputs, or stop toggling them. When reset is released, the block waits through an activation window before it accepts commands. The release is first passed through a two-flop synchronizer, and then a counter runs for a parameterized number of cycles. Throughout the window all outputs stay low, CKE included. A status flag, `act_done`, goes high on the cycle in which the register starts capturing inputs.

Top module: `regcmd_buffer`

## Requirements
- R1: While `act_done` is high, each output equals the matching input that was sampled at the previous rising edge of `clk`.
- R2: While `rst_n` is low, every output and `act_done` are low, with no need for a clock edge and whatever the inputs are.
- R3: After `rst_n` rises, `act_done` stays low for the first ACT_CYCLES+1 rising edges and goes high at rising edge ACT_CYCLES+2. The count is two synchronizer edges plus ACT_CYCLES counting edges.
- R4: While `act_done` is low, the value captured into `out_cke` is low, even when `in_cke` is high.
- R5: While `act_done` is low, the address, chip-select and command-strobe outputs are also captured as all zeros.
- R6: Once high, `act_done` stays high until `rst_n` falls. The first command forwarded is the one presented while `act_done` is already high.
- R7: A reset asserted in the middle of normal operation clears the outputs at once, and its release starts a full activation window again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_addr | input | ADDR_W | Address from the host |
| in_cs_n | input | CS_W | Chip selects from the host, active low |
| in_ras_n | input | 1 | Row strobe from the host |
| in_cas_n | input | 1 | Column strobe from the host |
| in_we_n | input | 1 | Write enable from the host |
| in_cke | input | 1 | Clock enable from the host |
| out_addr | output | ADDR_W | Registered address to the devices |
| out_cs_n | output | CS_W | Registered chip selects |
| out_ras_n | output | 1 | Registered row strobe |
| out_cas_n | output | 1 | Registered column strobe |
| out_we_n | output | 1 | Registered write enable |
| out_cke | output | 1 | Registered clock enable, held low while gated |
| act_done | output | 1 | High once the activation window has ended |

## Verification
Inputs are held all-ones through the activation window, so any output that leaks before the flag rises shows up as a one. The flag is checked at every edge of that window, which separates an off-by-one in the synchronizer or the counter from a correct count. After activation, the bench drives walking-one addresses, alternating bit patterns, a running count and pseudo-random words. These tell a true one-cycle delay apart from a zero-cycle or two-cycle path, and they expose any swapped or stuck lanes. A reset dropped in mid-cycle, with the inputs still toggling, separates an asynchronous clear from a synchronous one and shows that the window restarts in full.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;
  // Width of a counter that must reach the value n.
  function automatic int unsigned cnt_width(input int unsigned n);
    cnt_width = (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // Rising edges after release until the flag is high.
  function automatic int unsigned ready_edge(input int unsigned n);
    ready_edge = n + 2;
  endfunction
endpackage

// File: rtl/regcmd_rst_sync.sv
module regcmd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rel_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rel_sync = chain[STAGES-1];
endmodule

// File: rtl/regcmd_act_timer.sv
module regcmd_act_timer
  import regcmd_pkg::*;
#(
  parameter int unsigned ACT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rel_sync,
  output logic act_done
);
  localparam int unsigned CW = cnt_width(ACT_CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(ACT_CYCLES);

  logic [CW-1:0] cnt;
  logic          at_limit;

  assign at_limit = (cnt == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (!rel_sync)          cnt <= '0;
    else if (!at_limit)          cnt <= cnt + 1'b1;
  end

  assign act_done = rel_sync && at_limit;
endmodule

// File: rtl/regcmd_pipe.sv
module regcmd_pipe #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[g] <= 1'b0;
        else        q[g] <= load_en & d[g];
      end
    end
  endgenerate
endmodule

// File: rtl/regcmd_buffer.sv
module regcmd_buffer #(
  parameter int unsigned ADDR_W     = 14,
  parameter int unsigned CS_W       = 2,
  parameter int unsigned ACT_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [CS_W-1:0]   in_cs_n,
  input  logic              in_ras_n,
  input  logic              in_cas_n,
  input  logic              in_we_n,
  input  logic              in_cke,
  output logic [ADDR_W-1:0] out_addr,
  output logic [CS_W-1:0]   out_cs_n,
  output logic              out_ras_n,
  output logic              out_cas_n,
  output logic              out_we_n,
  output logic              out_cke,
  output logic              act_done
);
  localparam int unsigned BUS_W = ADDR_W + CS_W + 4;

  logic             rel_sync;
  logic             load_en;
  logic [BUS_W-1:0] in_bus;
  logic [BUS_W-1:0] out_bus;

  // Bus order, MSB first: cke, we_n, cas_n, ras_n, cs_n, addr
  assign in_bus = {in_cke, in_we_n, in_cas_n, in_ras_n, in_cs_n, in_addr};

  regcmd_rst_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .rel_sync(rel_sync)
  );

  regcmd_act_timer #(.ACT_CYCLES(ACT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .rel_sync(rel_sync), .act_done(load_en)
  );

  regcmd_pipe #(.W(BUS_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .d(in_bus), .q(out_bus)
  );

  assign {out_cke, out_we_n, out_cas_n, out_ras_n, out_cs_n, out_addr} = out_bus;
  assign act_done = load_en;
endmodule

// File: rtl/regcmd_buffer_chk.sv
module regcmd_buffer_chk #(
  parameter int unsigned W = 20
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rel_sync,
  input logic         act_done,
  input logic [W-1:0] in_bus,
  input logic [W-1:0] out_bus
);
  // R1: forwarded one edge later while active
  p_forward_r1: assert property (@(posedge clk) disable iff (!rst_n)
    act_done |=> (out_bus == $past(in_bus)));

  // R2: reset holds every output low
  p_reset_low_r2: assert property (@(posedge clk)
    !rst_n |-> (out_bus == '0 && !act_done));

  // R3: flag never precedes the synchronized release
  p_flag_after_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act_done |-> rel_sync);

  // R4: CKE gated low during the window
  p_cke_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !act_done |=> !out_bus[W-1]);

  // R5: remaining lines gated low during the window
  p_lines_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !act_done |=> (out_bus[W-2:0] == '0));

  // R6: flag is sticky until reset
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_done |=> act_done);
endmodule

bind regcmd_buffer regcmd_buffer_chk #(.W(BUS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rel_sync(rel_sync), .act_done(act_done),
  .in_bus(in_bus), .out_bus(out_bus)
);

// File: tb/regcmd_buffer_tb.sv
module regcmd_buffer_tb_top;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 14;
  localparam int CS_W   = 2;
  localparam int ACT    = 5;
  localparam int W      = ADDR_W + CS_W + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] stim = '0;
  logic [W-1:0] obs;
  logic act_done;
  int n_cmp = 0;
  int n_bad = 0;
  bit sb_on = 1'b0;
  logic [W-1:0] exp_q[$];

  logic [ADDR_W-1:0] o_addr;
  logic [CS_W-1:0]   o_cs;
  logic o_ras, o_cas, o_we, o_cke;

  always #(CLK_P/2) clk = ~clk;

  regcmd_buffer #(.ADDR_W(ADDR_W), .CS_W(CS_W), .ACT_CYCLES(ACT)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_addr(stim[ADDR_W-1:0]), .in_cs_n(stim[ADDR_W+CS_W-1:ADDR_W]),
    .in_ras_n(stim[W-4]), .in_cas_n(stim[W-3]), .in_we_n(stim[W-2]),
    .in_cke(stim[W-1]),
    .out_addr(o_addr), .out_cs_n(o_cs), .out_ras_n(o_ras), .out_cas_n(o_cas),
    .out_we_n(o_we), .out_cke(o_cke), .act_done(act_done)
  );

  assign obs = {o_cke, o_we, o_cas, o_ras, o_cs, o_addr};

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: present a word and queue what must appear after the next edge
  task automatic drive(logic [W-1:0] v);
    @(negedge clk);
    stim = v;
    exp_q.push_back(v);
  endtask

  // Monitor: compare a quarter period after each rising edge
  always begin
    @(posedge clk);
    #(CLK_P/4);
    if (sb_on && exp_q.size() > 0) begin
      logic [W-1:0] e;
      e = exp_q.pop_front();
      check("R1 pipeline", obs, e);
    end
  end

  // Release reset and walk the window edge by edge (R3, R4, R5)
  task automatic window(string tag);
    @(negedge clk);
    stim = '1;
    rst_n = 1'b1;
    for (int i = 1; i <= ACT + 2; i++) begin
      @(posedge clk);
      #(CLK_P/4);
      check({tag, " R3 flag"}, W'(act_done), W'(i == ACT + 2));
      check({tag, " R4 cke gated"}, W'(o_cke), '0);
      check({tag, " R5 lines gated"}, {1'b0, obs[W-2:0]}, '0);
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    stim = '1;
    repeat (3) @(negedge clk);
    check("R2 reset state", obs, '0);
    check("R2 reset flag", W'(act_done), '0);

    window("first");

    // R6: first command presented while the flag is high is forwarded
    sb_on = 1'b1;
    for (int i = 0; i < ADDR_W; i++) drive(W'(1) << i);
    drive({W{1'b0}} | W'(20'hAAAAA));
    drive(W'(20'h55555));
    for (int i = 0; i < 16; i++) drive(W'(i * 37 + 3));
    for (int i = 0; i < 40; i++) drive(W'($urandom));
    drive('1);
    drive('0);
    repeat (2) @(negedge clk);
    check("R1 queue drained", W'(exp_q.size()), '0);
    check("R6 flag sticky", W'(act_done), W'(1));

    // R7 / R2: asynchronous reset in mid-cycle
    sb_on = 1'b0;
    stim = '1;
    @(posedge clk);
    #(CLK_P/4);
    check("R1 before reset", obs, '1);
    #1;
    rst_n = 1'b0;
    #1;
    check("R2 async clear", obs, '0);
    check("R2 async flag", W'(act_done), '0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      stim = W'($urandom);
      @(posedge clk);
      #(CLK_P/4);
      check("R2 held low", obs, '0);
    end

    window("R7 restart");
    exp_q.delete();
    sb_on = 1'b1;
    for (int i = 0; i < 8; i++) drive(W'($urandom));
    repeat (2) @(negedge clk);
    check("R7 queue drained", W'(exp_q.size()), '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule